// File: doc/BRIEF.md
# Acceptance-Rate Fuzzy Bus Arbiter

This block shares one bus among three processors. Each processor's record is a pair of counts: the cycles in which it asked for the bus and the cycles in which it got it. Its acceptance rate is the percentage of its requests that were granted. Each rate goes through three triangular membership functions (low, medium, high) on a 0 to 255 scale, and the rate takes the label of the function that responds most strongly.

In every cycle a grant goes to the requester whose rate has the weakest label. Requesters that share the weakest label are ordered by a fixed priority, with processor 0 on top. Over time this pulls the processors that are served least back toward an even share.

The grant is registered and one-hot. The three rates come out for observation. All breakpoints and slopes of the membership functions are parameters.

Top module: `rate_fuzzy_arbiter`

## Requirements
- R1: While reset is asserted and after it is released, `grant_o` is all zero and every rate on `rate_o` reads 0 until the first request is counted.
- R2: `grant_o` has at most one bit set. A bit can be set only in the cycle after the same processor's `req_i` bit was sampled high.
- R3: When exactly one processor requests, it receives the grant in the next cycle.
- R4: Each processor's rate field is floor(100 × granted / requested), taken from its counters. It reads 0 while the request count is zero, and it moves in the same cycle that the grant for the counted request appears.
- R5: With the default parameters, rates 0 to 25 are labelled low, 26 to 75 medium and 76 to 100 high. The label order is low < medium < high.
- R6: Among the requesters, the grant goes to the one whose rate has the lowest label.
- R7: When several requesters share the lowest label, the lowest processor index wins. Processor 0 is highest and processor 2 is lowest.
- R8: If a processor's request count is 255 and it requests again, both of its counts are halved (shifted right by one) before that request and its grant are added.
- R9: A cycle with no request produces no grant. A processor that does not request keeps its rate unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_i | input | 3 | Bus request, one bit per processor (bit i is processor i) |
| grant_o | output | 3 | Registered one-hot grant, bit i is processor i |
| rate_o | output | 21 | Acceptance rates, 7 bits per processor, processor i in bits [7i+6:7i] |

## Verification
A request sampled at a clock edge shows its effect one cycle later. The grant and both updated counters, and so the new rate, appear together just after that same edge. The label that decides a grant comes from the counts before that edge. The bench model follows this timing. It computes the expected grant from its own counts, then advances those counts. It drives inputs and samples outputs a few nanoseconds after each rising edge, so every comparison reads values that have settled. Requests start only after the internal reset synchronizer has released.

// File: rtl/fz_arb_pkg.sv
package fz_arb_pkg;

  localparam int RATE_W = 7;
  localparam int MU_W   = 8;
  localparam int MU_MAX = 255;

  typedef enum logic [1:0] {
    CAT_LOW  = 2'd0,
    CAT_MED  = 2'd1,
    CAT_HIGH = 2'd2
  } fz_cat_e;

  // Triangular membership on a 0..MU_MAX scale.
  // below p_rise: 0; between p_rise and p_fall: rising, capped;
  // at or above p_fall: falling, floored at 0.
  function automatic int tri_mu(input int x, input int p_rise, input int p_fall,
                                input int s_rise, input int s_fall);
    int v;
    if (x < p_rise) begin
      v = 0;
    end else if (x < p_fall) begin
      v = (x - p_rise) * s_rise;
      if (v > MU_MAX) v = MU_MAX;
    end else begin
      v = (x - p_fall) * s_fall;
      if (v >= MU_MAX) v = 0;
      else v = MU_MAX - v;
    end
    return v;
  endfunction

endpackage

// File: rtl/fz_rate_track.sv
module fz_rate_track
  import fz_arb_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              won,
  output logic [RATE_W-1:0] rate
);

  localparam int PROD_W = CNT_W + 7;
  localparam logic [CNT_W-1:0] CNT_FULL = {CNT_W{1'b1}};

  logic [CNT_W-1:0]  req_cnt_q, req_cnt_d;
  logic [CNT_W-1:0]  won_cnt_q, won_cnt_d;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] quot;
  logic [CNT_W-1:0]  req_base, won_base;

  always_comb begin
    if (req && (req_cnt_q == CNT_FULL)) begin
      req_base = req_cnt_q >> 1;
      won_base = won_cnt_q >> 1;
    end else begin
      req_base = req_cnt_q;
      won_base = won_cnt_q;
    end
    if (req) begin
      req_cnt_d = req_base + {{(CNT_W-1){1'b0}}, 1'b1};
      won_cnt_d = won_base + {{(CNT_W-1){1'b0}}, won};
    end else begin
      req_cnt_d = req_cnt_q;
      won_cnt_d = won_cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_cnt_q <= '0;
      won_cnt_q <= '0;
    end else if (req) begin
      req_cnt_q <= req_cnt_d;
      won_cnt_q <= won_cnt_d;
    end
  end

  always_comb begin
    prod = {{(PROD_W-CNT_W){1'b0}}, won_cnt_q} * PROD_W'(100);
    if (req_cnt_q == '0) quot = '0;
    else quot = prod / {{(PROD_W-CNT_W){1'b0}}, req_cnt_q};
    rate = quot[RATE_W-1:0];
  end

endmodule

// File: rtl/fz_member.sv
module fz_member
  import fz_arb_pkg::*;
#(
  parameter int LO_RISE = 0,   parameter int LO_FALL = 0,
  parameter int LO_SR   = 5,   parameter int LO_SF   = 5,
  parameter int MD_RISE = 0,   parameter int MD_FALL = 50,
  parameter int MD_SR   = 5,   parameter int MD_SF   = 5,
  parameter int HI_RISE = 50,  parameter int HI_FALL = 100,
  parameter int HI_SR   = 5,   parameter int HI_SF   = 5
) (
  input  logic [RATE_W-1:0] rate,
  output fz_cat_e           cat
);

  logic [MU_W-1:0] mu_lo, mu_md, mu_hi;

  always_comb begin
    mu_lo = MU_W'(tri_mu(int'(rate), LO_RISE, LO_FALL, LO_SR, LO_SF));
    mu_md = MU_W'(tri_mu(int'(rate), MD_RISE, MD_FALL, MD_SR, MD_SF));
    mu_hi = MU_W'(tri_mu(int'(rate), HI_RISE, HI_FALL, HI_SR, HI_SF));
    if ((mu_lo >= mu_md) && (mu_lo >= mu_hi)) cat = CAT_LOW;
    else if (mu_md >= mu_hi)                  cat = CAT_MED;
    else                                      cat = CAT_HIGH;
  end

endmodule

// File: rtl/fz_select.sv
module fz_select
  import fz_arb_pkg::*;
#(
  parameter int NUM_PROC = 3
) (
  input  logic [NUM_PROC-1:0] req,
  input  fz_cat_e             cat [NUM_PROC],
  output logic [NUM_PROC-1:0] pick
);

  localparam int IDX_W = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1;

  logic [IDX_W-1:0] best_idx;
  fz_cat_e          best_cat;
  logic             any;

  always_comb begin
    best_idx = '0;
    best_cat = CAT_HIGH;
    any      = 1'b0;
    // scan downward so that on equal label the lower index overrides
    for (int i = NUM_PROC - 1; i >= 0; i--) begin
      if (req[i] && (!any || (cat[i] <= best_cat))) begin
        best_idx = IDX_W'(i);
        best_cat = cat[i];
        any      = 1'b1;
      end
    end
    pick = '0;
    if (any) pick[best_idx] = 1'b1;
  end

endmodule

// File: rtl/rate_fuzzy_arbiter.sv
module rate_fuzzy_arbiter
  import fz_arb_pkg::*;
#(
  parameter int NUM_PROC = 3,
  parameter int CNT_W    = 8,
  parameter int LO_RISE = 0,   parameter int LO_FALL = 0,
  parameter int LO_SR   = 5,   parameter int LO_SF   = 5,
  parameter int MD_RISE = 0,   parameter int MD_FALL = 50,
  parameter int MD_SR   = 5,   parameter int MD_SF   = 5,
  parameter int HI_RISE = 50,  parameter int HI_FALL = 100,
  parameter int HI_SR   = 5,   parameter int HI_SF   = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PROC-1:0]        req_i,
  output logic [NUM_PROC-1:0]        grant_o,
  output logic [NUM_PROC*RATE_W-1:0] rate_o
);

  logic [1:0]          rst_sync_q;
  logic                rst_int_n;
  logic [NUM_PROC-1:0] pick;
  logic [NUM_PROC-1:0] grant_q;
  fz_cat_e             cat [NUM_PROC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  for (genvar g = 0; g < NUM_PROC; g++) begin : g_proc
    logic [RATE_W-1:0] rate;

    fz_rate_track #(.CNT_W(CNT_W)) u_track (
      .clk  (clk),
      .rst_n(rst_int_n),
      .req  (req_i[g]),
      .won  (pick[g]),
      .rate (rate)
    );

    fz_member #(
      .LO_RISE(LO_RISE), .LO_FALL(LO_FALL), .LO_SR(LO_SR), .LO_SF(LO_SF),
      .MD_RISE(MD_RISE), .MD_FALL(MD_FALL), .MD_SR(MD_SR), .MD_SF(MD_SF),
      .HI_RISE(HI_RISE), .HI_FALL(HI_FALL), .HI_SR(HI_SR), .HI_SF(HI_SF)
    ) u_member (
      .rate(rate),
      .cat (cat[g])
    );

    assign rate_o[g*RATE_W +: RATE_W] = rate;
  end

  fz_select #(.NUM_PROC(NUM_PROC)) u_select (
    .req (req_i),
    .cat (cat),
    .pick(pick)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) grant_q <= '0;
    else            grant_q <= pick;
  end

  assign grant_o = grant_q;

endmodule

// File: rtl/fz_arb_checker.sv
module fz_arb_checker
  import fz_arb_pkg::*;
#(
  parameter int NUM_PROC = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_PROC-1:0]        req_i,
  input logic [NUM_PROC-1:0]        grant_o,
  input logic [NUM_PROC*RATE_W-1:0] rate_o
);

  logic [2:0] live_q;
  logic       live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 3'b000;
    else        live_q <= {live_q[1:0], 1'b1};
  end
  assign live = live_q[2];

  p_onehot_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  p_serve_some_r3: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(req_i != '0) |-> (grant_o != '0));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(req_i == '0) |-> (grant_o == '0));

  for (genvar g = 0; g < NUM_PROC; g++) begin : g_chk
    p_grant_had_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      live && grant_o[g] |-> $past(req_i[g]));

    p_rate_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rate_o[g*RATE_W +: RATE_W] <= RATE_W'(100));

    p_rate_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      live && !$past(req_i[g]) |-> $stable(rate_o[g*RATE_W +: RATE_W]));
  end

endmodule

bind rate_fuzzy_arbiter fz_arb_checker #(.NUM_PROC(NUM_PROC)) u_fz_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .req_i  (req_i),
  .grant_o(grant_o),
  .rate_o (rate_o)
);

// File: tb/sim_rate_fuzzy_arbiter.sv
`timescale 1ns/1ps
module sim_rate_fuzzy_arbiter;

  localparam int NP = 3;
  localparam int RW = 7;

  logic          clk;
  logic          rst_n;
  logic [NP-1:0] req_i;
  logic [NP-1:0] grant_o;
  logic [NP*RW-1:0] rate_o;

  int checks;
  int failures;
  int mreq [NP];
  int mwon [NP];
  bit done;

  rate_fuzzy_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .grant_o(grant_o), .rate_o(rate_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int m_rate(input int i);
    if (mreq[i] == 0) return 0;
    return (mwon[i] * 100) / mreq[i];
  endfunction

  // label by R5: 0 low, 1 medium, 2 high
  function automatic int m_cat(input int i);
    int r;
    r = m_rate(i);
    if (r <= 25) return 0;
    if (r <= 75) return 1;
    return 2;
  endfunction

  task automatic check_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive, predict, advance model, compare after the edge
  task automatic step(input logic [NP-1:0] r);
    int best;
    int ties;
    int nreq;
    logic [NP-1:0] exp_g;
    string tag;
    req_i = r;
    best = -1;
    nreq = 0;
    for (int i = 0; i < NP; i++) begin
      if (r[i]) begin
        nreq++;
        if (best < 0 || m_cat(i) < m_cat(best)) best = i;
      end
    end
    ties = 0;
    if (best >= 0)
      for (int i = 0; i < NP; i++) if (r[i] && m_cat(i) == m_cat(best)) ties++;
    exp_g = '0;
    if (best >= 0) exp_g[best] = 1'b1;
    if (nreq == 0)      tag = "R9 idle grant";
    else if (nreq == 1) tag = "R3 lone grant";
    else if (ties > 1)  tag = "R7 tie grant";
    else                tag = "R6 R5 label grant";
    for (int i = 0; i < NP; i++) begin
      if (r[i]) begin
        if (mreq[i] == 255) begin
          mreq[i] = mreq[i] / 2;
          mwon[i] = mwon[i] / 2;
        end
        mreq[i]++;
        if (exp_g[i]) mwon[i]++;
      end
    end
    @(posedge clk);
    #2;
    check_int(tag, int'(grant_o), int'(exp_g));
    for (int i = 0; i < NP; i++)
      check_int("R4 R8 rate", int'(rate_o[i*RW +: RW]), m_rate(i));
  endtask

  initial begin
    checks = 0;
    failures = 0;
    done = 1'b0;
    for (int i = 0; i < NP; i++) begin
      mreq[i] = 0;
      mwon[i] = 0;
    end
    req_i = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check_int("R1 grant in reset", int'(grant_o), 0);
    check_int("R1 rates in reset", int'(rate_o), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    check_int("R1 grant after reset", int'(grant_o), 0);
    check_int("R1 rates after reset", int'(rate_o), 0);

    // R7: all rates 0, all low: processor 0 wins
    step(3'b111);
    check_int("R7 first tie to p0", int'(grant_o), 1);
    // p1 and p2 now 0 rate, p0 at 100 (high): p1 wins over p2 by R7, p0 loses by R6
    step(3'b111);
    check_int("R6 high label loses", int'(grant_o), 2);
    // lone requester
    for (int k = 0; k < 20; k++) step(3'b100);
    // idle cycles: rates held, no grant (R9)
    for (int k = 0; k < 5; k++) step(3'b000);
    // saturation of processor 1 counter (R8)
    for (int k = 0; k < 300; k++) step(3'b010);
    // mixed contention patterns
    for (int k = 0; k < 400; k++) step(3'b011);
    for (int k = 0; k < 400; k++) step(3'b111);
    for (int k = 0; k < 4000; k++) step(3'($urandom_range(0, 7)));
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule